// File: doc/BRIEF.md
# Three-Bus Datapath with PC Incrementer

This block is the execution core of a small register machine built around three internal buses. A register file with two read ports and one write port drives bus A and bus B straight into the two ALU inputs. The ALU result returns to the destination register over bus C. Both source reads and the write therefore happen in the same clock cycle. The program counter has its own incrementer, so the ALU never handles address arithmetic and its A input has no multiplexer.

Each instruction takes two phases. In the fetch phase the core requests the word at the PC on a simple ready/valid instruction port. It waits as long as the memory needs. When the word arrives it loads the word into the instruction register, and the PC advances by the fixed 4-byte instruction length. The execute phase follows, and it lasts exactly one cycle. In that cycle the register file reads both sources, the ALU combines them, and the result is written back. The three buses and the write-back controls are brought out as ports, so that a checker or a trace unit can follow every transfer.

Top module: `tribus_core`

## Requirements
- R1: After reset the core is in fetch with `imem_req_o`=1, `imem_addr_o`=0, `exec_o`=0 and `wb_en_o`=0, and every register holds zero.
- R2: While fetching with `imem_valid_i` low, the core keeps `imem_req_o` high, keeps `imem_addr_o` stable and writes no register.
- R3: A fetch completes on a cycle with `imem_req_o` and `imem_valid_i` both high. In the next cycle `exec_o`=1, `imem_req_o`=0 and `imem_addr_o` equals the previous address plus 4.
- R4: Execute lasts exactly one cycle, and fetch follows it. `imem_req_o` and `exec_o` are never high together.
- R5: During execute, `bus_a_o` carries the register selected by bits [23:20] and `bus_b_o` carries the register selected by bits [19:16]. For the load-immediate opcode, `bus_b_o` instead carries bits [15:0] zero-extended.
- R6: During execute, `bus_c_o` carries the ALU result selected by opcode bits [31:28]: 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 XOR, 5 load immediate (passes bus B). Arithmetic wraps modulo 2^32.
- R7: For opcodes 0 to 5, `wb_en_o` is high during execute and `wb_idx_o` equals bits [27:24]. Opcodes 6 to 15 write nothing, and the register that bits [27:24] name keeps its value. `wb_en_o` is low outside execute.
- R8: An instruction whose source is also its destination reads the old value on its bus. The value it writes is seen by the next instruction.
- R9: Register 0 is an ordinary register that can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_req_o | output | 1 | Instruction request, high during fetch |
| imem_addr_o | output | AW | Fetch address (current PC) |
| imem_valid_i | input | 1 | Instruction word valid |
| imem_rdata_i | input | 32 | Instruction word |
| exec_o | output | 1 | High during the execute step |
| bus_a_o | output | DW | Bus A, first ALU operand |
| bus_b_o | output | DW | Bus B, second ALU operand |
| bus_c_o | output | DW | Bus C, ALU result |
| wb_en_o | output | 1 | Register write enable |
| wb_idx_o | output | IDX_W | Destination register index |

## Verification
The assertions assume that the instruction memory raises `imem_valid_i` only while `imem_req_o` is high. They also assume that `imem_rdata_i` is a complete word when it is accepted. The bench keeps to this: it drives valid for exactly one cycle, only after it has seen a request, and it holds valid low for zero to several cycles first so that the wait path is exercised. Opcode fields outside 0 to 5 appear only in directed no-write cases. Register contents are observed through bus A and bus B of later instructions, never from inside the design.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned ILEN    = 4;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_LDI = 4'd5
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PASSB
  } alu_op_e;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_EXEC  = 1'b1
  } state_e;
endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int unsigned NREG  = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic [DW-1:0]    ra_data_o,
  output logic [DW-1:0]    rb_data_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= '0;
      else if (we_i && (wr_idx_i == IDX_W'(g)))
        regs_q[g] <= wr_data_i;
    end
  end

  // Reads come straight from the array, so a same-cycle write is not seen until the next cycle.
  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];
endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_AND:   y_o = a_i & b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_XOR:   y_o = a_i ^ b_i;
      ALU_PASSB: y_o = b_i;
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/tribus_pc_unit.sv
module tribus_pc_unit #(
  parameter int unsigned AW       = 32,
  parameter int unsigned STEP     = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_next;

  // Dedicated adder; the ALU is never used for the PC.
  assign pc_next = pc_q + AW'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= RESET_PC;
    else if (adv_i) pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/tribus_ctrl.sv
module tribus_ctrl
  import tribus_pkg::*;
#(
  parameter int unsigned NREG  = 16,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] rdata_i,
  output logic               req_o,
  output logic               fetch_done_o,
  output logic               exec_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic [IDX_W-1:0]   ra_o,
  output logic [IDX_W-1:0]   rb_o,
  output logic [IDX_W-1:0]   rd_o,
  output logic               we_o,
  output logic               use_imm_o,
  output logic [15:0]        imm_o,
  output alu_op_e            alu_op_o
);
  state_e             state_q;
  logic [INSTR_W-1:0] ir_q;
  logic [3:0]         opc;

  assign req_o        = (state_q == ST_FETCH);
  assign exec_o       = (state_q == ST_EXEC);
  assign fetch_done_o = req_o && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
    end else if (fetch_done_o) begin
      state_q <= ST_EXEC;
      ir_q    <= rdata_i;
    end else if (exec_o) begin
      state_q <= ST_FETCH;
    end
  end

  assign instr_o   = ir_q;
  assign opc       = ir_q[31:28];
  assign rd_o      = ir_q[24 +: IDX_W];
  assign ra_o      = ir_q[20 +: IDX_W];
  assign rb_o      = ir_q[16 +: IDX_W];
  assign imm_o     = ir_q[15:0];
  assign use_imm_o = (opc == OP_LDI);

  always_comb begin
    alu_op_o = ALU_ADD;
    we_o     = 1'b0;
    unique case (opc)
      OP_ADD: begin alu_op_o = ALU_ADD;   we_o = exec_o; end
      OP_SUB: begin alu_op_o = ALU_SUB;   we_o = exec_o; end
      OP_AND: begin alu_op_o = ALU_AND;   we_o = exec_o; end
      OP_OR:  begin alu_op_o = ALU_OR;    we_o = exec_o; end
      OP_XOR: begin alu_op_o = ALU_XOR;   we_o = exec_o; end
      OP_LDI: begin alu_op_o = ALU_PASSB; we_o = exec_o; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tribus_core.sv
module tribus_core
  import tribus_pkg::*;
#(
  parameter int unsigned NREG     = 16,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int unsigned IDX_W   = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               imem_req_o,
  output logic [AW-1:0]      imem_addr_o,
  input  logic               imem_valid_i,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  output logic               exec_o,
  output logic [DW-1:0]      bus_a_o,
  output logic [DW-1:0]      bus_b_o,
  output logic [DW-1:0]      bus_c_o,
  output logic               wb_en_o,
  output logic [IDX_W-1:0]   wb_idx_o
);
  logic               fetch_done;
  logic [INSTR_W-1:0] instr_q;
  logic [IDX_W-1:0]   ra_idx, rb_idx, rd_idx;
  logic               we, use_imm;
  logic [15:0]        imm;
  alu_op_e            alu_op;
  logic [DW-1:0]      rf_a, rf_b, bus_a, bus_b, bus_c;

  tribus_ctrl #(.NREG(NREG)) u_ctrl (
    .clk_i, .rst_ni,
    .valid_i      (imem_valid_i),
    .rdata_i      (imem_rdata_i),
    .req_o        (imem_req_o),
    .fetch_done_o (fetch_done),
    .exec_o       (exec_o),
    .instr_o      (instr_q),
    .ra_o         (ra_idx),
    .rb_o         (rb_idx),
    .rd_o         (rd_idx),
    .we_o         (we),
    .use_imm_o    (use_imm),
    .imm_o        (imm),
    .alu_op_o     (alu_op)
  );

  tribus_pc_unit #(.AW(AW), .STEP(ILEN), .RESET_PC(RESET_PC)) u_pc (
    .clk_i, .rst_ni,
    .adv_i (fetch_done),
    .pc_o  (imem_addr_o)
  );

  tribus_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .ra_idx_i  (ra_idx),
    .rb_idx_i  (rb_idx),
    .ra_data_o (rf_a),
    .rb_data_o (rf_b),
    .we_i      (we),
    .wr_idx_i  (rd_idx),
    .wr_data_i (bus_c)
  );

  // Bus A has no mux; bus B selects the immediate for load-immediate.
  assign bus_a = rf_a;
  assign bus_b = use_imm ? DW'(imm) : rf_b;

  tribus_alu #(.DW(DW)) u_alu (
    .op_i (alu_op),
    .a_i  (bus_a),
    .b_i  (bus_b),
    .y_o  (bus_c)
  );

  assign bus_a_o  = bus_a;
  assign bus_b_o  = bus_b;
  assign bus_c_o  = bus_c;
  assign wb_en_o  = we;
  assign wb_idx_o = rd_idx;
endmodule

// File: rtl/tribus_core_chk.sv
module tribus_core_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             imem_req_o,
  input logic [AW-1:0]    imem_addr_o,
  input logic             imem_valid_i,
  input logic             exec_o,
  input logic [DW-1:0]    bus_a_o,
  input logic [DW-1:0]    bus_b_o,
  input logic [DW-1:0]    bus_c_o,
  input logic             wb_en_o,
  input logic [IDX_W-1:0] wb_idx_o,
  input logic [31:0]      instr_i
);
  a_r2_fetch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o && !imem_valid_i |=> imem_req_o && $stable(imem_addr_o));

  a_r3_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o && imem_valid_i |=> exec_o && (imem_addr_o == $past(imem_addr_o) + AW'(4)));

  a_r4_single_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o && imem_req_o);

  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_o && imem_req_o));

  a_r6_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && instr_i[31:28] == 4'd0 |-> bus_c_o == bus_a_o + bus_b_o);

  a_r6_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && instr_i[31:28] == 4'd1 |-> bus_c_o == bus_a_o - bus_b_o);

  a_r7_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |-> !wb_en_o);

  a_r7_nop_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && instr_i[31:28] > 4'd5 |-> !wb_en_o);

  a_r7_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_idx_o == instr_i[24 +: IDX_W]);
endmodule

bind tribus_core tribus_core_chk #(.DW(DW), .AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .imem_req_o, .imem_addr_o, .imem_valid_i, .exec_o,
  .bus_a_o, .bus_b_o, .bus_c_o, .wb_en_o, .wb_idx_o,
  .instr_i (instr_q)
);

// File: tb/tribus_core_tb.sv
module tribus_core_tb;
  localparam int NREG = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_req_o, imem_valid_i, exec_o, wb_en_o;
  logic [31:0] imem_addr_o, imem_rdata_i, bus_a_o, bus_b_o, bus_c_o;
  logic [3:0]  wb_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ref_rf [NREG];
  logic [31:0] ref_pc;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tribus_core u_dut (
    .clk_i, .rst_ni, .imem_req_o, .imem_addr_o, .imem_valid_i, .imem_rdata_i,
    .exec_o, .bus_a_o, .bus_b_o, .bus_c_o, .wb_en_o, .wb_idx_o
  );

  function automatic logic [31:0] enc(input int op, input int rd, input int ra, input int rb,
                                      input int imm);
    return {op[3:0], rd[3:0], ra[3:0], rb[3:0], imm[15:0]};
  endfunction

  // Table: op, rd, rs1, rs2/imm packed as instruction words.
  localparam logic [31:0] TBL [16] = '{
    {4'd5, 4'd5,  4'd0, 4'd0,  16'h1234},  // LDI R5
    {4'd5, 4'd6,  4'd0, 4'd0,  16'hFFFF},  // LDI R6
    {4'd0, 4'd4,  4'd5, 4'd6,  16'h0000},  // ADD R4,R5,R6
    {4'd5, 4'd0,  4'd0, 4'd0,  16'h00A5},  // LDI R0 (R9)
    {4'd1, 4'd7,  4'd0, 4'd5,  16'h0000},  // SUB wraps
    {4'd2, 4'd8,  4'd6, 4'd5,  16'h0000},  // AND
    {4'd3, 4'd9,  4'd4, 4'd0,  16'h0000},  // OR
    {4'd4, 4'd10, 4'd9, 4'd6,  16'h0000},  // XOR
    {4'd0, 4'd1,  4'd4, 4'd4,  16'h0000},  // ADD R1,R4,R4
    {4'd0, 4'd1,  4'd1, 4'd1,  16'h0000},  // R8 old value
    {4'd0, 4'd2,  4'd1, 4'd0,  16'h0000},  // R8 new value visible
    {4'd9, 4'd2,  4'd5, 4'd6,  16'hBEEF},  // no-write opcode
    {4'd0, 4'd3,  4'd2, 4'd0,  16'h0000},  // R2 unchanged
    {4'd15,4'd0,  4'd6, 4'd6,  16'h0000},  // no-write into R0
    {4'd0, 4'd0,  4'd0, 4'd0,  16'h0000},  // ADD R0,R0,R0 (R9)
    {4'd1, 4'd11, 4'd15,4'd0,  16'h0000}   // SUB from untouched R15
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] ins, input logic [31:0] a,
                                        input logic [31:0] b);
    case (ins[31:28])
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      default: return b;
    endcase
  endfunction

  // Runs one instruction; inputs change on the falling edge, outputs sampled there too.
  task automatic run(input logic [31:0] ins, input int stall);
    logic [31:0] a_exp, b_exp, c_exp;
    int op, rd;
    op = int'(ins[31:28]);
    rd = int'(ins[27:24]);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk_i);
      chk(imem_req_o && !wb_en_o && imem_addr_o == ref_pc, "R2 wait", imem_addr_o, ref_pc);
    end
    imem_rdata_i = ins;
    imem_valid_i = 1'b1;
    @(negedge clk_i);
    imem_valid_i = 1'b0;
    imem_rdata_i = 32'hDEAD_BEEF;
    ref_pc = ref_pc + 32'd4;
    chk(exec_o && !imem_req_o, "R3 exec", {30'd0, exec_o, imem_req_o}, 32'd2);
    chk(imem_addr_o == ref_pc, "R3 pc+4", imem_addr_o, ref_pc);
    a_exp = ref_rf[ins[23:20]];
    b_exp = (op == 5) ? {16'd0, ins[15:0]} : ref_rf[ins[19:16]];
    chk(bus_a_o == a_exp, "R5/R8 bus A", bus_a_o, a_exp);
    chk(bus_b_o == b_exp, "R5 bus B", bus_b_o, b_exp);
    if (op <= 5) begin
      c_exp = model(ins, a_exp, b_exp);
      chk(bus_c_o == c_exp, "R6 bus C", bus_c_o, c_exp);
      chk(wb_en_o && wb_idx_o == ins[27:24], "R7 write", {27'd0, wb_en_o, wb_idx_o},
          {27'd1, ins[27:24]});
      ref_rf[rd] = c_exp;
    end else begin
      chk(!wb_en_o, "R7 no write", {31'd0, wb_en_o}, 32'd0);
    end
    @(negedge clk_i);
    chk(!exec_o && imem_req_o && !wb_en_o, "R4 back to fetch", {30'd0, exec_o, imem_req_o},
        32'd1);
  endtask

  initial begin
    imem_valid_i = 1'b0;
    imem_rdata_i = '0;
    ref_pc = '0;
    for (int i = 0; i < NREG; i++) ref_rf[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(imem_req_o && !exec_o && !wb_en_o, "R1 reset ctrl", {29'd0, imem_req_o, exec_o, wb_en_o},
        32'd4);
    chk(imem_addr_o == 32'd0, "R1 reset pc", imem_addr_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(imem_req_o && imem_addr_o == 32'd0, "R1 after release", imem_addr_o, 32'd0);
    // R1: all registers zero, read back through the buses
    for (int i = 0; i < NREG; i += 2) run(enc(0, 15, i, i + 1, 0), 0);
    for (int i = 0; i < 16; i++) run(TBL[i], i % 3);
    // R8 and R9 directed: R0 written and read right after
    run(enc(5, 0, 0, 0, 16'h7777), 1);
    run(enc(0, 0, 0, 0, 0), 0);
    run(enc(0, 12, 0, 0, 0), 0);
    // Random ADD sequences checked against the reference array
    for (int i = 0; i < 60; i++) begin
      if (i % 10 == 0) run(enc(5, $urandom_range(15), 0, 0, $urandom_range(65535)), 0);
      else run(enc(0, $urandom_range(15), $urandom_range(15), $urandom_range(15), 0),
               $urandom_range(2));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule